// File: doc/BRIEF.md
# Serial Link Transmit Frame Builder

This block builds one transmit frame around each Frame Information Structure (FIS) for a serial storage link. The FIS arrives as 32-bit Dwords on a valid/ready stream, and a last marker flags its final Dword. On its output stream the block sends a start delimiter, then the FIS Dwords unchanged and in order, then one 32-bit CRC Dword, then an end delimiter. A flag beside each output Dword says whether it is a control primitive or data.

The CRC covers the FIS Dwords only. Its register is seeded again at every frame start and advances one whole Dword per accepted input. The output is a single register stage. When the downstream side stalls, that stage holds its contents, and no input is taken until the stage is free again. A FIS longer than the configured limit is cut off at the limit and the frame is flagged. The Dwords that remain on the input then begin a new frame.

Top module: `frame_tx_builder`

## Requirements
- R1: During and just after reset, out_valid, in_ready and out_trunc are all 0.
- R2: Each frame goes out in this order: the start primitive 32'h3737B57C with out_ctrl=1, then the FIS Dwords in arrival order, then the CRC Dword, then the end primitive 32'hD5D5B57C with out_ctrl=1. A Dword with out_ctrl=1 is always one of these two primitives.
- R3: FIS Dwords and the CRC Dword go out with out_ctrl=0. An input Dword accepted in one cycle appears on the output as data in the next cycle.
- R4: The CRC register is seeded with 32'h52325032 at each frame start. The CRC uses polynomial 32'h04C11DB7 and shifts in each FIS Dword from bit 31 down to bit 0, with no bit reflection and no final inversion. The delimiters are not included. The CRC Dword is the register value after the last FIS Dword.
- R5: in_ready is 1 only while a FIS is being taken and the output stage is free (out_valid=0 or out_ready=1). Input presented between frames, or during the start, CRC or end step, is not consumed.
- R6: While out_valid=1 and out_ready=0, the next cycle keeps out_valid=1 and leaves out_data and out_ctrl unchanged.
- R7: A one-Dword FIS gives a four-Dword frame. Frames may follow each other without idle input cycles between them.
- R8: If no last marker has arrived by FIS Dword number MAX_FIS_DWORDS (2048 by default), that Dword closes the FIS. out_trunc rises together with that Dword and stays 1 through the end primitive until the next start primitive is loaded. The remaining input Dwords form the next frame.
- R9: A frame whose last marker arrives at or before the limit, including exactly at the limit, has out_trunc=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input FIS Dword is valid |
| in_data | input | 32 | Input FIS Dword |
| in_last | input | 1 | Marks the final Dword of the FIS |
| in_ready | output | 1 | Block accepts the input Dword in this cycle |
| out_valid | output | 1 | Output Dword is valid |
| out_data | output | 32 | Output Dword: primitive, FIS data or CRC |
| out_ctrl | output | 1 | 1 = control primitive, 0 = data |
| out_ready | input | 1 | Downstream accepts the output Dword |
| out_trunc | output | 1 | Current or latest frame was cut off at the length limit |

## Verification
The assertions check on every cycle that the output holds still while stalled, that input is taken only when the output stage is free, that any Dword flagged as control is one of the two delimiters, that an accepted input shows up as data in the next cycle, and that the truncation flag rises only together with a data Dword. The order of the frame, the CRC value against an independent reference, the split of an oversized FIS at the limit and the flag's value at each end delimiter can be shown only by the bench's scenarios. Those scenarios compare every output Dword of every frame while the input has random gaps and the output has random stalls.

// File: rtl/fb_pkg.sv
package fb_pkg;

    localparam int FB_DW = 32;

    localparam logic [FB_DW-1:0] FB_PRIM_SOF = 32'h3737B57C;
    localparam logic [FB_DW-1:0] FB_PRIM_EOF = 32'hD5D5B57C;
    localparam logic [FB_DW-1:0] FB_CRC_SEED = 32'h52325032;
    localparam logic [FB_DW-1:0] FB_CRC_POLY = 32'h04C11DB7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_DATA,
        ST_CRC,
        ST_EOF
    } fb_state_e;

    typedef struct packed {
        fb_state_e          st;
        logic               out_valid;
        logic [FB_DW-1:0]   out_data;
        logic               out_ctrl;
        logic               trunc;
        logic [FB_DW-1:0]   crc;
    } fb_regs_t;

endpackage

// File: rtl/fb_crc_step.sv
// One full-word CRC update, unrolled as a chain of single-bit stages.
module fb_crc_step #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
    input  logic [W-1:0] crc_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] crc_o
);

    logic [W:0][W-1:0] chain;

    assign chain[0] = crc_i;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic fb;
        assign fb           = chain[g][W-1] ^ data_i[W-1-g];
        assign chain[g+1]   = {chain[g][W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end

    assign crc_o = chain[W];

endmodule

// File: rtl/fb_len_count.sv
// Counts accepted FIS Dwords and flags the final allowed position.
module fb_len_count #(
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST_POS = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != LAST_POS)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_limit = (cnt_q == LAST_POS);

endmodule

// File: rtl/frame_tx_builder.sv
module frame_tx_builder
    import fb_pkg::*;
#(
    parameter int MAX_FIS_DWORDS = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FB_DW-1:0] in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [FB_DW-1:0] out_data,
    output logic             out_ctrl,
    input  logic             out_ready,
    output logic             out_trunc
);

    fb_regs_t         r_d, r_q;
    logic             stage_free;
    logic             take;
    logic             at_limit;
    logic [FB_DW-1:0] crc_next;

    assign stage_free = !r_q.out_valid || out_ready;
    assign in_ready   = (r_q.st == ST_DATA) && stage_free;
    assign take       = in_ready && in_valid;

    fb_crc_step #(
        .W    (FB_DW),
        .POLY (FB_CRC_POLY)
    ) i_crc (
        .crc_i  (r_q.crc),
        .data_i (in_data),
        .crc_o  (crc_next)
    );

    fb_len_count #(
        .LIMIT (MAX_FIS_DWORDS)
    ) i_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (r_q.st == ST_SOF),
        .inc      (take),
        .at_limit (at_limit)
    );

    always_comb begin
        r_d = r_q;
        if (stage_free) begin
            r_d.out_valid = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.st = ST_SOF;
                end
            end
            ST_SOF: begin
                if (stage_free) begin
                    r_d.out_valid = 1'b1;
                    r_d.out_data  = FB_PRIM_SOF;
                    r_d.out_ctrl  = 1'b1;
                    r_d.trunc     = 1'b0;
                    r_d.crc       = FB_CRC_SEED;
                    r_d.st        = ST_DATA;
                end
            end
            ST_DATA: begin
                if (take) begin
                    r_d.out_valid = 1'b1;
                    r_d.out_data  = in_data;
                    r_d.out_ctrl  = 1'b0;
                    r_d.crc       = crc_next;
                    if (in_last || at_limit) begin
                        r_d.st = ST_CRC;
                    end
                    if (at_limit && !in_last) begin
                        r_d.trunc = 1'b1;
                    end
                end
            end
            ST_CRC: begin
                if (stage_free) begin
                    r_d.out_valid = 1'b1;
                    r_d.out_data  = r_q.crc;
                    r_d.out_ctrl  = 1'b0;
                    r_d.st        = ST_EOF;
                end
            end
            ST_EOF: begin
                if (stage_free) begin
                    r_d.out_valid = 1'b1;
                    r_d.out_data  = FB_PRIM_EOF;
                    r_d.out_ctrl  = 1'b1;
                    r_d.st        = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.out_valid <= 1'b0;
            r_q.out_data  <= '0;
            r_q.out_ctrl  <= 1'b0;
            r_q.trunc     <= 1'b0;
            r_q.crc       <= FB_CRC_SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.out_valid;
    assign out_data  = r_q.out_data;
    assign out_ctrl  = r_q.out_ctrl;
    assign out_trunc = r_q.trunc;

endmodule

// File: rtl/fb_checks.sv
module fb_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        out_ctrl,
    input logic        out_ready,
    input logic        out_trunc
);

    AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid || out_ready)); // R5

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl))); // R6

    AST_CTRL_IS_DELIM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl) |-> ((out_data == 32'h3737B57C) || (out_data == 32'hD5D5B57C))); // R2

    AST_TAKEN_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !out_ctrl)); // R3

    AST_TRUNC_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_trunc) |-> (out_valid && !out_ctrl)); // R8

endmodule

bind frame_tx_builder fb_checks i_fb_checks (.*);

// File: tb/test_frame_tx_builder.sv
`timescale 1ns/1ps
module test_frame_tx_builder;

    localparam int          MAXD = 2048;
    localparam logic [31:0] SOFW = 32'h3737B57C;
    localparam logic [31:0] EOFW = 32'hD5D5B57C;
    localparam logic [31:0] SEED = 32'h52325032;
    localparam logic [31:0] POLY = 32'h04C11DB7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ctrl;
    logic        out_ready = 1'b1;
    logic        out_trunc;

    int checks = 0;
    int failures = 0;
    int stall_pct = 0;

    logic [31:0] payload[$];
    logic [32:0] exp_w[$];
    string       exp_tag[$];
    logic        exp_trunc[$];

    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    logic        prev_ctrl = 1'b0;

    frame_tx_builder #(.MAX_FIS_DWORDS(MAXD)) i_frame_tx_builder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ctrl  (out_ctrl),
        .out_ready (out_ready),
        .out_trunc (out_trunc)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Word-at-once reference: xor the Dword in, then 32 conditional shifts.
    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] x;
        x = c ^ w;
        for (int k = 0; k < 32; k++) begin
            x = x[31] ? ((x << 1) ^ POLY) : (x << 1);
        end
        return x;
    endfunction

    task automatic expect_payload();
        int idx = 0;
        while (idx < payload.size()) begin
            int n;
            logic [31:0] c;
            n = payload.size() - idx;
            if (n > MAXD) n = MAXD;
            exp_w.push_back({1'b1, SOFW}); exp_tag.push_back("R2 sof");
            c = SEED;
            for (int k = 0; k < n; k++) begin
                exp_w.push_back({1'b0, payload[idx+k]}); exp_tag.push_back("R3 fis data");
                c = ref_step(c, payload[idx+k]);
            end
            exp_w.push_back({1'b0, c}); exp_tag.push_back("R4 crc");
            exp_w.push_back({1'b1, EOFW}); exp_tag.push_back("R2 eof");
            exp_trunc.push_back((n == MAXD) && (idx + n < payload.size()));
            idx += n;
        end
    endtask

    task automatic drive_payload(input int gap_pct);
        for (int i = 0; i < payload.size(); i++) begin
            bit ok;
            while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = payload[i];
            in_last  = (i == payload.size() - 1);
            do begin
                @(negedge clk);
                ok = in_ready;
                @(posedge clk); #1;
            end while (!ok);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic fill_random(input int n);
        payload.delete();
        for (int i = 0; i < n; i++) payload.push_back($urandom);
    endtask

    task automatic wait_drain(input string tag);
        int t = 0;
        while (exp_w.size() != 0 && t < 20000) begin
            @(posedge clk); #1;
            t++;
        end
        repeat (4) @(posedge clk);
        #1;
        chk(exp_w.size() == 0, tag, 64'(exp_w.size()), 64'd0);
    endtask

    // Output monitor: compares every handshaked Dword with the expected stream.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(out_valid && out_data == prev_data && out_ctrl == prev_ctrl,
                    "R6 stall hold", {31'd0, out_ctrl, out_data}, {31'd0, prev_ctrl, prev_data});
            end
            if (out_valid && !out_ready) begin
                chk(!in_ready, "R5 no input while stalled", 64'(in_ready), 64'd0);
            end
            if (out_valid && out_ready) begin
                if (exp_w.size() == 0) begin
                    chk(1'b0, "R2 unexpected output", {31'd0, out_ctrl, out_data}, 64'd0);
                end else begin
                    logic [32:0] e;
                    string tg;
                    e  = exp_w.pop_front();
                    tg = exp_tag.pop_front();
                    chk({out_ctrl, out_data} == e, tg, {31'd0, out_ctrl, out_data}, {31'd0, e});
                    if (e == {1'b1, EOFW} && exp_trunc.size() != 0) begin
                        logic et;
                        et = exp_trunc.pop_front();
                        chk(out_trunc == et, et ? "R8 trunc flag" : "R9 no trunc flag",
                            64'(out_trunc), 64'(et));
                    end
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_ctrl  = out_ctrl;
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = (stall_pct == 0) || (($urandom % 100) >= stall_pct);
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !in_ready && !out_trunc, "R1 in reset",
            {61'd0, out_valid, in_ready, out_trunc}, 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !in_ready && !out_trunc, "R1 after reset",
            {61'd0, out_valid, in_ready, out_trunc}, 64'd0);
    endtask

    task automatic t_idle();
        int seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_valid || in_ready) seen++;
        end
        chk(seen == 0, "R5 idle produces nothing", 64'(seen), 64'd0);
    endtask

    task automatic t_single();
        stall_pct = 0;
        payload.delete();
        payload.push_back(32'h00000000);
        expect_payload();
        drive_payload(0);
        wait_drain("R7 single dword frame");
        payload.delete();
        payload.push_back(32'hFFFFFFFF);
        expect_payload();
        drive_payload(0);
        wait_drain("R7 single dword frame ones");
    endtask

    task automatic t_back_to_back();
        stall_pct = 0;
        for (int f = 0; f < 8; f++) begin
            fill_random(1 + f * 3);
            expect_payload();
            drive_payload(0);
        end
        wait_drain("R7 back to back frames");
    endtask

    task automatic t_random_stalls();
        stall_pct = 35;
        for (int f = 0; f < 25; f++) begin
            fill_random(1 + ($urandom % 40));
            expect_payload();
            drive_payload(25);
        end
        wait_drain("R4 random frames with stalls");
        stall_pct = 0;
    endtask

    task automatic t_truncate();
        stall_pct = 0;
        fill_random(MAXD + 1);
        expect_payload();
        drive_payload(0);
        wait_drain("R8 oversize fis split");
        fill_random(MAXD);
        expect_payload();
        drive_payload(0);
        wait_drain("R9 fis at exact limit");
        @(negedge clk);
        chk(!out_trunc, "R9 flag low after exact frame", 64'(out_trunc), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_single();
        t_back_to_back();
        t_random_stalls();
        t_truncate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule